// File: doc/BRIEF.md
# Double-Buffered Transmit Packet Buffer

This block sits between a CPU and a serial transmit engine. It holds two packet buffers of 64 bytes each. The CPU fills one buffer while the engine drains the other. The CPU sees a single data-push port and a single byte-count port. Which physical buffer is being loaded or sent is tracked inside the block and is never visible to the CPU. The CPU pushes bytes, then writes the byte count to hand the packet over. That write drops the buffer-available flag. If the second buffer is already free, the flag comes straight back.

On the engine side, a ready indication and a packet length are presented for the oldest committed packet. The engine pops bytes one at a time and then pulses a done strobe, which returns that buffer to the free pool. Packets always reach the engine in the order they were committed. The engine can therefore build a long isochronous payload of up to 1023 bytes by chaining consecutive loads, as long as the CPU keeps both buffers supplied.

Top module: `dbl_tx_buffer`

## Requirements
- R1: After reset `buf_avail` is 1 and `eng_ready` is 0.
- R2: After N bytes are pushed and the count N is written (N from 0 to 64), on the next cycle `eng_ready` is 1 and `eng_len` equals N. `eng_data` then shows the pushed bytes in push order, advancing by one on each `eng_pop`.
- R3: When the count is written while the other buffer is free, `buf_avail` is 1 on the following cycle.
- R4: When the count is written while the other buffer still holds an unsent packet, `buf_avail` is 0 on the following cycle and stays 0 until a done strobe.
- R5: When `eng_done` is pulsed while `eng_ready` is 1, the buffer being sent is freed. If the CPU held no free buffer, `buf_avail` is 1 on the next cycle.
- R6: Committed packets are presented to the engine strictly in commit order.
- R7: Pushes after 64 bytes have been loaded into the current buffer are dropped. The first 64 bytes are kept unchanged.
- R8: A byte-count write above 64 (the count port is 8 bits wide) commits a packet of length 64.
- R9: While `buf_avail` is 0, pushes and byte-count writes are ignored. They change neither the buffer being loaded next nor the length of any waiting packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_push | input | 1 | Push one data byte into the buffer being loaded |
| cpu_data | input | 8 | Byte to push |
| cpu_bc_wr | input | 1 | Byte-count write; commits the loaded packet |
| cpu_bc | input | 8 | Packet length to commit (clamped to 64) |
| buf_avail | output | 1 | A free buffer is held for CPU loading |
| eng_ready | output | 1 | A committed packet is waiting for the engine |
| eng_len | output | 7 | Length of the waiting packet |
| eng_data | output | 8 | Byte at the engine's read position |
| eng_pop | input | 1 | Advance the read position by one byte |
| eng_done | input | 1 | Engine finished the packet; free its buffer |

## Verification
The main load/send cycle is swept over every packet length from 0 to 64. Each length uses a byte pattern computed from the length and position, so a wrong count, a misplaced address or a bank mix-up shows up as a data or length mismatch. A second pattern commits two packets back to back so that both buffers are full. It then pushes and writes counts while the flag is low, which separates correct dropping from a pointer or length that was silently disturbed. Finally an over-long load of 70 bytes and a count of 200 probe the two limits on size.

// File: rtl/dtx_pkg.sv
// Shared types for the double-buffered transmit buffer.
// Assumes exactly two physical buffers; one bit names either of them.
package dtx_pkg;
    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_id_t;

    // Name of the partner bank.
    function automatic bank_id_t other_bank(input bank_id_t b);
        return bank_id_t'(~b);
    endfunction
endpackage

// File: rtl/dtx_bank.sv
// One packet buffer: a simple single-port-write, asynchronous-read byte store.
// Assumes the controller keeps write and read addresses in range.
// Storage is not reset; the controller tracks validity separately.
module dtx_bank #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store [DEPTH];

    // Capture one byte per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Present the byte at the read position without delay.
    assign rd_data = store[rd_addr];
endmodule

// File: rtl/dtx_ctrl.sv
// Ownership and pointer control for two transmit buffers.
// The CPU side always loads cpu_bank; the engine side always reads send_bank.
// Both advance in strict alternation, so packets leave in commit order.
// Assumes BCW is at least the pointer width (count port can express DEPTH).
module dtx_ctrl
    import dtx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int BCW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_push,
    input  logic           cpu_bc_wr,
    input  logic [BCW-1:0] cpu_bc,
    input  logic           eng_pop,
    input  logic           eng_done,
    output logic           buf_avail,
    output logic           eng_ready,
    output logic [PW-1:0]  eng_len,
    output logic           wr_en,
    output bank_id_t       wr_bank,
    output logic [AW-1:0]  wr_addr,
    output bank_id_t       rd_bank,
    output logic [AW-1:0]  rd_addr
);
    logic [1:0]    full_q;
    logic [PW-1:0] len_q [2];
    bank_id_t      cpu_bank, send_bank;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, commit_ok, pop_ok, done_ok;
    logic [PW-1:0] commit_len;

    // Flags and lengths seen by the two sides.
    assign buf_avail = ~full_q[cpu_bank];
    assign eng_ready = full_q[send_bank];
    assign eng_len   = len_q[send_bank];

    // Accepted actions.
    assign push_ok   = cpu_push && buf_avail && (wr_ptr < PW'(DEPTH));
    assign commit_ok = cpu_bc_wr && buf_avail;
    assign pop_ok    = eng_pop && eng_ready && (rd_ptr < eng_len);
    assign done_ok   = eng_done && eng_ready;

    // Limit a requested length to the buffer size.
    assign commit_len = (cpu_bc > BCW'(DEPTH)) ? PW'(DEPTH) : cpu_bc[PW-1:0];

    // Memory access steering.
    assign wr_en   = push_ok;
    assign wr_bank = cpu_bank;
    assign wr_addr = wr_ptr[AW-1:0];
    assign rd_bank = send_bank;
    assign rd_addr = rd_ptr[AW-1:0];

    // Full flags: set on commit, cleared on done (never the same bank at once).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            if (commit_ok) full_q[cpu_bank]  <= 1'b1;
            if (done_ok)   full_q[send_bank] <= 1'b0;
        end
    end

    // Stored packet lengths, written at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q[0] <= '0;
            len_q[1] <= '0;
        end else if (commit_ok) begin
            len_q[cpu_bank] <= commit_len;
        end
    end

    // Bank selectors for each side, toggled by their own hand-off events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_bank  <= BANK_LO;
            send_bank <= BANK_LO;
        end else begin
            if (commit_ok) cpu_bank  <= other_bank(cpu_bank);
            if (done_ok)   send_bank <= other_bank(send_bank);
        end
    end

    // CPU load position: advance on accepted push, restart on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (commit_ok) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Engine read position: advance on pop, restart on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (done_ok) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (buf_avail && !eng_ready));

    assert_commit_lo_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok && cpu_bank == BANK_LO) |=> full_q[0]);

    assert_commit_hi_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok && cpu_bank == BANK_HI) |=> full_q[1]);

    assert_read_in_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ready |-> (rd_ptr <= eng_len));

    assert_done_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !buf_avail) |=> buf_avail);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PW'(DEPTH));

    assert_len_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q[0] <= PW'(DEPTH)) && (len_q[1] <= PW'(DEPTH)));

    assert_busy_push_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_avail && cpu_push) |=> $stable(wr_ptr));

    assert_busy_len_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_avail && !done_ok) |=> ($stable(len_q[0]) && $stable(len_q[1])));
endmodule

// File: rtl/dbl_tx_buffer.sv
// Double-buffered transmit packet buffer, top level.
// Two byte stores behind a controller that hides the bank choice from the CPU.
// Assumes the engine pops no further than eng_len and pulses eng_done once per packet.
module dbl_tx_buffer
    import dtx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int BCW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_push,
    input  logic [DW-1:0]  cpu_data,
    input  logic           cpu_bc_wr,
    input  logic [BCW-1:0] cpu_bc,
    output logic           buf_avail,
    output logic           eng_ready,
    output logic [PW-1:0]  eng_len,
    output logic [DW-1:0]  eng_data,
    input  logic           eng_pop,
    input  logic           eng_done
);
    logic          wr_en;
    bank_id_t      wr_bank, rd_bank;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] bank_rd [2];

    dtx_ctrl #(.DEPTH(DEPTH), .BCW(BCW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_push  (cpu_push),
        .cpu_bc_wr (cpu_bc_wr),
        .cpu_bc    (cpu_bc),
        .eng_pop   (eng_pop),
        .eng_done  (eng_done),
        .buf_avail (buf_avail),
        .eng_ready (eng_ready),
        .eng_len   (eng_len),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr)
    );

    // One store per bank; writes steered by the controller's bank choice.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        dtx_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk     (clk),
            .wr_en   (wr_en && (wr_bank == bank_id_t'(g))),
            .wr_addr (wr_addr),
            .wr_data (cpu_data),
            .rd_addr (rd_addr),
            .rd_data (bank_rd[g])
        );
    end

    // Engine sees the bank currently being sent.
    assign eng_data = bank_rd[rd_bank];
endmodule

// File: tb/dbl_tx_buffer_tb.sv
module dbl_tx_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_push = 1'b0;
    logic [7:0] cpu_data = '0;
    logic       cpu_bc_wr = 1'b0;
    logic [7:0] cpu_bc = '0;
    logic       buf_avail, eng_ready;
    logic [6:0] eng_len;
    logic [7:0] eng_data;
    logic       eng_pop = 1'b0;
    logic       eng_done = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    dbl_tx_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_push(cpu_push), .cpu_data(cpu_data),
        .cpu_bc_wr(cpu_bc_wr), .cpu_bc(cpu_bc), .buf_avail(buf_avail),
        .eng_ready(eng_ready), .eng_len(eng_len), .eng_data(eng_data),
        .eng_pop(eng_pop), .eng_done(eng_done)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) ^ (i >> 3));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            cpu_push = 1'b1;
            cpu_data = pat(seed, i);
            @(negedge clk);
        end
        cpu_push = 1'b0;
    endtask

    task automatic commit(input int bc);
        cpu_bc_wr = 1'b1;
        cpu_bc = 8'(bc);
        @(negedge clk);
        cpu_bc_wr = 1'b0;
    endtask

    // Check length and the first n_data bytes, then release with done.
    task automatic read_pkt(input string tag, input int exp_len, input int n_data, input int seed);
        chk({tag, " ready"}, int'(eng_ready), 1);
        chk({tag, " len"}, int'(eng_len), exp_len);
        for (int i = 0; i < n_data; i++) begin
            chk({tag, " data"}, int'(eng_data), int'(pat(seed, i)));
            eng_pop = 1'b1;
            @(negedge clk);
        end
        eng_pop = 1'b0;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 avail", int'(buf_avail), 1);
        chk("R1 ready", int'(eng_ready), 0);

        // R2/R3: sweep every length; alternates banks along the way.
        for (int n = 0; n <= 64; n++) begin
            push_bytes(n, n);
            commit(n);
            chk("R3 avail after commit", int'(buf_avail), 1);
            read_pkt("R2 sweep", n, n, n);
            chk("R2 ready cleared", int'(eng_ready), 0);
        end

        // R4/R5/R6/R9: fill both banks, poke while busy.
        push_bytes(4, 100);
        commit(4);
        chk("R3 first of pair", int'(buf_avail), 1);
        push_bytes(6, 101);
        commit(6);
        chk("R4 avail low", int'(buf_avail), 0);
        push_bytes(3, 102);
        commit(9);
        chk("R4 still low", int'(buf_avail), 0);
        read_pkt("R6 first packet", 4, 4, 100);
        chk("R5 avail after done", int'(buf_avail), 1);
        push_bytes(5, 103);
        commit(5);
        read_pkt("R9 waiting len kept", 6, 6, 101);
        read_pkt("R9 pushes dropped", 5, 5, 103);
        chk("R6 drained", int'(eng_ready), 0);

        // R7: over-long load.
        push_bytes(70, 200);
        commit(64);
        read_pkt("R7 overflow", 64, 64, 200);

        // R8: count above size.
        push_bytes(10, 201);
        commit(200);
        read_pkt("R8 clamp", 64, 10, 201);
        chk("R8 avail", int'(buf_avail), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule